// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt and Wake Detector

This block is the register slice behind one general-purpose I/O pin. It takes the pin level after filtering, decides whether that level or a change in it is a trigger event, and records the event in two sticky status bits. One bit is for interrupts and one is for wake-up. It also holds the direction and drive value for the pin's output buffer. Software reaches it through one register word. Writes are per bit: a bit changes only where its strobe is set. The status bits are cleared by writing ones to them, so writing back the word just read clears exactly the events that were seen.

Triggering is either edge based or level based, with a two-bit polarity selector. Delivery is split between an enable bit and a mask bit. The enable bit decides whether interrupt events are captured at all. The mask bit decides whether captured status is reported on the pending flag. Three wake-enable bits, one per low-power state, decide whether a trigger event sets the wake status while the system is in that state. An external block-window input suppresses all status capture while it is high.

Top module: `gpio_pin_irq_slice`

## Requirements
- R1: After reset, every configuration and status bit of the register word reads 0, and `pending`, `wakeReq`, `padOe` and `padOut` are 0.
- R2: The register word is laid out as follows. Bit 0 selects the trigger mode (0 = edge, 1 = level). Bits 2:1 hold the polarity. Bit 3 is the interrupt enable and bit 4 is the unmask. Bits 7:5 are the wake enables for sleep states 1, 2 and 3. Bit 8 is the output enable and bit 9 is the output value. Bit 10 is the read-only input level. Bit 11 is the interrupt status and bit 12 is the wake status. Bits 9:0 take `wrData` only where `wrStrobe` is 1. Writes to bit 10 and bits 31:13 have no effect, and bits 31:13 read 0.
- R3: In edge mode with polarity 00, a rising input sets the interrupt status on the clock edge at which the new level is first sampled. A falling input does not set it.
- R4: In edge mode, polarity 01 triggers on a falling input only and polarity 10 triggers on both edges. Polarity 11 never triggers.
- R5: In level mode, polarity 00 triggers on every clock while the input is 1 and polarity 01 on every clock while it is 0. Status therefore remains set after a clear while the input stays active. Polarities 10 and 11 never trigger in level mode.
- R6: While the interrupt enable (bit 3) is 0, trigger events do not set the interrupt status.
- R7: Writing 1 to a status bit with its strobe set clears it one clock later. Writing 0 leaves it set. Status never clears by itself. A trigger event in the same clock as a clear leaves the bit set.
- R8: `pending` is 1 exactly when bit 4 is 1 and at least one of the two status bits is 1.
- R9: The wake status is set by a trigger event only while `sleepState` is k (1 to 3) and wake-enable bit k-1 is set. This is independent of the interrupt enable. It is never set in state 0. `wakeReq` follows the wake status.
- R10: While `blockWin` is 1, neither status bit is set by a trigger event.
- R11: `padOe` follows bit 8 and `padOut` follows bit 9. Bit 10 shows `pinLevel` in the same cycle, without a register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinLevel | input | 1 | Filtered input level of the pin |
| blockWin | input | 1 | Suppresses status capture while high |
| sleepState | input | 2 | Current power state, 0 = running, 1..3 = low-power states |
| wrData | input | 32 | Register write data |
| wrStrobe | input | 32 | Per-bit write strobes |
| regImage | output | 32 | Readable register word |
| pending | output | 1 | Unmasked status is present |
| wakeReq | output | 1 | Wake status is set |
| padOe | output | 1 | Output buffer enable |
| padOut | output | 1 | Output drive value |

## Verification
Configuration writes and status capture take effect on the first rising clock edge that samples them, so they show one cycle later. `pending`, `padOe`, `padOut` and the input-level bit are combinational from registers or the pin, so they follow in the same cycle. The bench drives every input on the falling edge. A behavioural model advances on each rising edge. The outputs are compared with the model a few nanoseconds after that edge, when every register in the path has settled. Edge-versus-clear collisions and level-mode re-capture after a clear are produced on purpose, so each due cycle is compared exactly.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  parameter int REG_W  = 32;
  parameter int WAKE_N = 3;
  localparam int SLP_W = $clog2(WAKE_N + 1);

  localparam int B_TRIG  = 0;
  localparam int B_POL   = 1;
  localparam int B_EN    = 3;
  localparam int B_UNM   = 4;
  localparam int B_WAKE  = 5;
  localparam int B_OE    = B_WAKE + WAKE_N;
  localparam int B_OV    = B_OE + 1;
  localparam int B_INLVL = B_OV + 1;
  localparam int B_IRQST = B_INLVL + 1;
  localparam int B_WKST  = B_IRQST + 1;
  localparam int CFG_W   = B_OV + 1;
  localparam int USED_W  = B_WKST + 1;

  typedef enum logic [1:0] {
    POL_HIGH = 2'b00,
    POL_LOW  = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } polSel_e;

  typedef struct packed {
    logic              trigLevel;
    polSel_e           pol;
    logic              irqEn;
    logic [WAKE_N-1:0] wakeEn;
  } trigCfg_t;

  typedef struct packed {
    trigCfg_t trig;
    logic     unmask;
    logic     outEn;
    logic     outVal;
  } pinCfg_t;

  typedef struct packed {
    logic setIrq;
    logic setWake;
    logic clrIrq;
    logic clrWake;
  } statStrobe_t;
endpackage

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinLevel,
  input  logic             blockWin,
  input  logic [SLP_W-1:0] sleepState,
  input  trigCfg_t         cfg,
  input  logic             irqClrReq,
  input  logic             wakeClrReq,
  output statStrobe_t      stb
);
  logic prevLevel;
  logic rise;
  logic fall;
  logic hit;
  logic [WAKE_N-1:0] wakeSel;
  logic wakeArm;

  // Last sampled level; tracks even while disabled so enabling never fakes an edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= pinLevel;
  end

  assign rise = pinLevel & ~prevLevel;
  assign fall = ~pinLevel & prevLevel;

  always_comb begin
    hit = 1'b0;
    if (!cfg.trigLevel) begin
      case (cfg.pol)
        POL_HIGH: hit = rise;
        POL_LOW:  hit = fall;
        POL_BOTH: hit = rise | fall;
        default:  hit = 1'b0;
      endcase
    end else begin
      case (cfg.pol)
        POL_HIGH: hit = pinLevel;
        POL_LOW:  hit = ~pinLevel;
        default:  hit = 1'b0;
      endcase
    end
  end

  // One wake enable per low-power state; state 0 (running) never arms wake.
  for (genvar k = 0; k < WAKE_N; k++) begin : g_wake
    assign wakeSel[k] = cfg.wakeEn[k] && (sleepState == SLP_W'(k + 1));
  end
  assign wakeArm = |wakeSel;

  always_comb begin
    stb.setIrq  = hit && cfg.irqEn && !blockWin;
    stb.setWake = hit && wakeArm && !blockWin;
    stb.clrIrq  = irqClrReq;
    stb.clrWake = wakeClrReq;
  end
endmodule

// File: rtl/pin_irq_dp.sv
module pin_irq_dp
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinLevel,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic [CFG_W-1:0] cfgWrStrobe,
  input  statStrobe_t      stb,
  output pinCfg_t          cfg,
  output logic             irqSt,
  output logic             wakeSt,
  output logic [REG_W-1:0] regImage
);
  logic [CFG_W-1:0] cfgBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgBits <= '0;
      irqSt   <= 1'b0;
      wakeSt  <= 1'b0;
    end else begin
      cfgBits <= (cfgBits & ~cfgWrStrobe) | (cfgWrData & cfgWrStrobe);
      // Capture beats clear so an event landing with the clear is not lost.
      irqSt   <= stb.setIrq  | (irqSt  & ~stb.clrIrq);
      wakeSt  <= stb.setWake | (wakeSt & ~stb.clrWake);
    end
  end

  always_comb begin
    cfg.trig.trigLevel = cfgBits[B_TRIG];
    cfg.trig.pol       = polSel_e'(cfgBits[B_POL +: 2]);
    cfg.trig.irqEn     = cfgBits[B_EN];
    cfg.trig.wakeEn    = cfgBits[B_WAKE +: WAKE_N];
    cfg.unmask         = cfgBits[B_UNM];
    cfg.outEn          = cfgBits[B_OE];
    cfg.outVal         = cfgBits[B_OV];
  end

  always_comb begin
    regImage           = '0;
    regImage[B_OV:0]   = cfgBits;
    regImage[B_INLVL]  = pinLevel;
    regImage[B_IRQST]  = irqSt;
    regImage[B_WKST]   = wakeSt;
  end
endmodule

// File: rtl/gpio_pin_irq_slice.sv
module gpio_pin_irq_slice
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinLevel,
  input  logic             blockWin,
  input  logic [SLP_W-1:0] sleepState,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] wrStrobe,
  output logic [REG_W-1:0] regImage,
  output logic             pending,
  output logic             wakeReq,
  output logic             padOe,
  output logic             padOut
);
  pinCfg_t     cfg;
  statStrobe_t stb;
  logic        irqSt;
  logic        wakeSt;
  logic        irqClrReq;
  logic        wakeClrReq;
  logic        unusedWrBits;

  assign irqClrReq  = wrStrobe[B_IRQST] & wrData[B_IRQST];
  assign wakeClrReq = wrStrobe[B_WKST]  & wrData[B_WKST];

  if (REG_W > USED_W) begin : g_spare
    assign unusedWrBits = ^{wrData[REG_W-1:USED_W], wrStrobe[REG_W-1:USED_W],
                            wrData[B_INLVL], wrStrobe[B_INLVL]};
  end else begin : g_nospare
    assign unusedWrBits = wrData[B_INLVL] ^ wrStrobe[B_INLVL];
  end

  pin_irq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pinLevel   (pinLevel),
    .blockWin   (blockWin),
    .sleepState (sleepState),
    .cfg        (cfg.trig),
    .irqClrReq  (irqClrReq),
    .wakeClrReq (wakeClrReq),
    .stb        (stb)
  );

  pin_irq_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pinLevel    (pinLevel),
    .cfgWrData   (wrData[CFG_W-1:0]),
    .cfgWrStrobe (wrStrobe[CFG_W-1:0]),
    .stb         (stb),
    .cfg         (cfg),
    .irqSt       (irqSt),
    .wakeSt      (wakeSt),
    .regImage    (regImage)
  );

  assign pending = (irqSt | wakeSt) & cfg.unmask;
  assign wakeReq = wakeSt;
  assign padOe   = cfg.outEn;
  assign padOut  = cfg.outVal;
endmodule

// File: rtl/gpio_pin_irq_checker.sv
module gpio_pin_irq_checker
  import gpio_irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             blockWin,
  input logic             sleepIdle,
  input logic             irqClrReq,
  input logic             wakeClrReq,
  input logic [REG_W-1:0] regImage,
  input logic             pending
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regImage >> USED_W) == '0);

  p_mask_gates_r8: assert property (@(posedge clk) disable iff (!rstN)
    !regImage[B_UNM] |-> !pending);

  p_pend_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> (regImage[B_IRQST] || regImage[B_WKST]));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regImage[B_IRQST] && !irqClrReq) |=> regImage[B_IRQST]);

  p_wake_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wakeClrReq && blockWin) |=> !regImage[B_WKST]);

  p_disarmed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!regImage[B_EN] && !regImage[B_IRQST]) |=> !regImage[B_IRQST]);

  p_block_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    (blockWin && !regImage[B_IRQST]) |=> !regImage[B_IRQST]);

  p_block_wake_r10: assert property (@(posedge clk) disable iff (!rstN)
    (blockWin && !regImage[B_WKST]) |=> !regImage[B_WKST]);

  p_awake_no_wake_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sleepIdle && !regImage[B_WKST]) |=> !regImage[B_WKST]);
endmodule

bind gpio_pin_irq_slice gpio_pin_irq_checker i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .blockWin   (blockWin),
  .sleepIdle  (sleepState == '0),
  .irqClrReq  (wrStrobe[gpio_irq_pkg::B_IRQST] & wrData[gpio_irq_pkg::B_IRQST]),
  .wakeClrReq (wrStrobe[gpio_irq_pkg::B_WKST] & wrData[gpio_irq_pkg::B_WKST]),
  .regImage   (regImage),
  .pending    (pending)
);

// File: tb/test_gpio_pin_irq_slice.sv
module test_gpio_pin_irq_slice;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinLevel = 1'b0;
  logic        blockWin = 1'b0;
  logic [1:0]  sleepState = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] wrStrobe = '0;
  logic [31:0] regImage;
  logic        pending, wakeReq, padOe, padOut;

  always #10 clk = ~clk;

  gpio_pin_irq_slice i_gpio_pin_irq_slice (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .blockWin(blockWin),
    .sleepState(sleepState), .wrData(wrData), .wrStrobe(wrStrobe),
    .regImage(regImage), .pending(pending), .wakeReq(wakeReq),
    .padOe(padOe), .padOut(padOut)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string curReq = "R1";

  // Behavioural model: config vector per R2, two sticky status flags, last sampled pin.
  bit [9:0] mCfg = '0;
  bit       mIrq = 0, mWs = 0, mPrev = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCfg = '0; mIrq = 0; mWs = 0; mPrev = 0;
    end else begin
      bit ev, armW;
      ev = 0;
      if (!mCfg[0]) begin
        if (mCfg[2:1] == 2'd0) ev = pinLevel && !mPrev;
        else if (mCfg[2:1] == 2'd1) ev = !pinLevel && mPrev;
        else if (mCfg[2:1] == 2'd2) ev = pinLevel != mPrev;
      end else begin
        if (mCfg[2:1] == 2'd0) ev = pinLevel;
        else if (mCfg[2:1] == 2'd1) ev = !pinLevel;
      end
      armW = (sleepState != 0) && mCfg[4 + sleepState];
      mIrq = (mCfg[3] && ev && !blockWin) || (mIrq && !(wrStrobe[11] && wrData[11]));
      mWs  = (armW && ev && !blockWin) || (mWs && !(wrStrobe[12] && wrData[12]));
      for (int i = 0; i < 10; i++) if (wrStrobe[i]) mCfg[i] = wrData[i];
      mPrev = pinLevel;
    end
  end

  function automatic logic [31:0] expImage();
    logic [31:0] e;
    e = '0;
    e[9:0] = mCfg;
    e[10] = pinLevel;
    e[11] = mIrq;
    e[12] = mWs;
    return e;
  endfunction

  task automatic note(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #4;
    if (!finished) begin
      note(regImage === expImage(), curReq, "regImage", regImage, expImage());
      note(pending === ((mIrq || mWs) && mCfg[4]), "R8", "pending",
           32'(pending), 32'((mIrq || mWs) && mCfg[4]));
      note(wakeReq === mWs, "R9", "wakeReq", 32'(wakeReq), 32'(mWs));
      note({padOe, padOut} === {mCfg[8], mCfg[9]}, "R11", "pad",
           32'({padOe, padOut}), 32'({mCfg[8], mCfg[9]}));
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] s, logic [31:0] d);
    @(negedge clk); wrStrobe = s; wrData = d;
    @(negedge clk); wrStrobe = '0; wrData = '0;
  endtask

  task automatic setPin(bit v);
    @(negedge clk); pinLevel = v;
    tick(2);
  endtask

  task automatic clearAll();
    wr(32'h0000_1800, 32'h0000_1800);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    curReq = "R1";
    tick(3);
    rstN = 1'b1;
    tick(2);

    curReq = "R2";
    wr(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    tick(1);
    wr(32'h0000_0006, 32'h0);
    wr(32'hFFFF_E400, 32'hFFFF_FFFF);
    wr(32'h0000_03FF, 32'h0);

    curReq = "R11";
    wr(32'h0000_0300, 32'h0000_0300);
    setPin(1); setPin(0);
    wr(32'h0000_0300, 32'h0000_0100);
    wr(32'h0000_0300, 32'h0);

    curReq = "R3";
    wr(32'h3FF, 32'h18);
    setPin(1); clearAll(); setPin(0); setPin(1); clearAll();

    curReq = "R4";
    wr(32'h3FF, 32'h1A);
    setPin(0); clearAll(); setPin(1);
    wr(32'h3FF, 32'h1C);
    setPin(0); clearAll(); setPin(1); clearAll();
    wr(32'h3FF, 32'h1E);
    setPin(0); setPin(1);

    curReq = "R5";
    wr(32'h3FF, 32'h19);
    clearAll(); clearAll(); setPin(0); clearAll();
    wr(32'h3FF, 32'h1B);
    clearAll(); setPin(1); clearAll();
    wr(32'h3FF, 32'h1D);
    setPin(0); setPin(1); clearAll();
    wr(32'h3FF, 32'h1F);
    setPin(0); setPin(1);

    curReq = "R6";
    wr(32'h3FF, 32'h10);
    setPin(0); setPin(1); setPin(0);

    curReq = "R7";
    wr(32'h3FF, 32'h18);
    setPin(1);
    wr(32'h1800, 32'h0);
    tick(2);
    setPin(0); clearAll();
    @(negedge clk); pinLevel = 1'b1; wrStrobe = 32'h1800; wrData = 32'h1800;
    @(negedge clk); wrStrobe = '0; wrData = '0;
    tick(2);

    curReq = "R8";
    wr(32'h10, 32'h0);
    tick(1);
    wr(32'h10, 32'h10);
    clearAll();

    curReq = "R9";
    wr(32'h3FF, 32'h30);
    setPin(0); setPin(1);
    @(negedge clk); sleepState = 2'd1;
    setPin(0); setPin(1); clearAll();
    @(negedge clk); sleepState = 2'd2;
    setPin(0); setPin(1);
    wr(32'h3FF, 32'hF0);
    setPin(0); setPin(1); clearAll();
    @(negedge clk); sleepState = 2'd3;
    setPin(0); setPin(1); clearAll();

    curReq = "R10";
    wr(32'h3FF, 32'hF8);
    @(negedge clk); blockWin = 1'b1;
    setPin(0); setPin(1); setPin(0); setPin(1);
    @(negedge clk); blockWin = 1'b0;
    setPin(0); setPin(1); clearAll();
    @(negedge clk); sleepState = 2'd0;
    tick(3);
    finishRun();
  end
endmodule